// File: doc/BRIEF.md
# Synchronous Serial Byte Shifter

This block exchanges one byte with an external partner over a three-wire synchronous link: a shift clock, a serial output and a serial input. Software loads the byte to send into the data lane of a 16-bit register word, selects a shift clock rate, and sets a start bit. The block then moves eight bits out and eight bits in, least significant bit first. When the last bit arrives it latches an interrupt request. The received byte replaces the sent byte in the same data lane.

The control lane of the register word holds the following fields. A three-bit clock mode selects one of seven divide ratios of an incoming prescaler tick, or an external shift clock. The other fields are an interrupt enable, a latched interrupt request, a read-only busy flag, a stop bit that freezes a transfer in place, and a trigger-only start bit. Because the block comes out of reset with stop set, software must clear stop before any bit can move. The register bus is a plain strobe interface. Writes take effect on the clock edge where the write strobe is high, and reads are combinational. Nothing on this interface can stall, so it has no back-pressure rules.

Top module: `ser_shift_ctl`

## Requirements
- R1: After reset, the control lane (rdata_o[15:8]) reads 0x02, meaning stop set, clock mode 000, interrupts disabled and request clear. The interrupt output is low and sclk_o is high.
- R2: Control lane bit positions are start=bit 8, stop=bit 9, busy=bit 10, request=bit 11, enable=bit 12 and clock mode=bits 15:13. Writing 1 to start launches a transfer only when mode_q_i is 0 and no transfer is running. Start always reads 0.
- R3: In internal modes, one sclk_o period lasts the divide ratio times the tick spacing. The ratios by code are 000→2, 001→4, 110→8, 010→16, 011→32, 100→64 and 111→128. sclk_o idles high.
- R4: A transfer drives sout_o on each falling shift clock edge and samples sin_i on each rising edge, least significant bit first. After the transfer, the data lane holds the received byte.
- R5: Mode code 101 takes the shift clock from sclk_i through a two-stage synchronizer. In this mode sclk_o stays high.
- R6: While stop is 1, the bit position and shift register hold and busy reads 0. Clearing stop resumes the transfer at the same bit, and the transfer completes with the correct data.
- R7: The request flag sets on the edge that samples the eighth bit. Busy reads 0 from then on.
- R8: irq_o is high exactly when both the request flag and the enable bit are 1.
- R9: Writing 0 to the request bit clears it. Writing 1 to it leaves it unchanged.
- R10: A data-lane write while a transfer is running is ignored.
- R11: The busy bit cannot be written. A control write with bit 10 set leaves busy at 0 when idle.
- R12: A lane is written only when its byte enable is set (be_i[1] for control, be_i[0] for data) and addr_i equals BASE_ADDR. Any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 16 | Write data: control lane [15:8], data lane [7:0] |
| be_i | input | 2 | Byte enables: [1] control lane, [0] data lane |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 16 | Read data, combinational |
| tick_i | input | 1 | Prescaler tick, one clock wide |
| mode_q_i | input | 1 | Start qualifier: transfers may start only while low |
| sclk_i | input | 1 | External shift clock |
| sin_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Internal shift clock out |
| sout_o | output | 1 | Serial data out |
| irq_o | output | 1 | Gated interrupt request |

## Verification
Register writes and the start trigger are visible one clock edge after the write strobe, and reads are valid in the same cycle. The bench therefore drives and samples at falling clock edges, one cycle after each write. With internal clocking, the spacing between falling sclk_o edges is measured in nanoseconds and divided by the clock period. This makes the ratio check exact, whatever the start-up offset of the divider. With the external clock, a pin edge reaches the shift logic on the third system clock edge. The bench therefore holds each sclk_i level for six cycles, and completion is detected by polling the request bit within a bounded cycle budget.

// File: rtl/ser_shift_pkg.sv
`timescale 1ns/1ps
package ser_shift_pkg;

  localparam int DATA_W = 8;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int CNT_W  = 7;

  // Control lane field positions (bit index inside the control byte)
  localparam int F_START = 0;
  localparam int F_STOP  = 1;
  localparam int F_BUSY  = 2;
  localparam int F_REQ   = 3;
  localparam int F_EN    = 4;
  localparam int F_MODE  = 5;

  typedef enum logic [2:0] {
    CK_DIV2   = 3'b000,
    CK_DIV4   = 3'b001,
    CK_DIV16  = 3'b010,
    CK_DIV32  = 3'b011,
    CK_DIV64  = 3'b100,
    CK_EXTERN = 3'b101,
    CK_DIV8   = 3'b110,
    CK_DIV128 = 3'b111
  } ck_mode_e;

  // Ticks per half shift clock period, minus one
  function automatic logic [CNT_W-1:0] half_limit(ck_mode_e m);
    case (m)
      CK_DIV2:   half_limit = CNT_W'(0);
      CK_DIV4:   half_limit = CNT_W'(1);
      CK_DIV8:   half_limit = CNT_W'(3);
      CK_DIV16:  half_limit = CNT_W'(7);
      CK_DIV32:  half_limit = CNT_W'(15);
      CK_DIV64:  half_limit = CNT_W'(31);
      CK_DIV128: half_limit = CNT_W'(63);
      default:   half_limit = CNT_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/ser_ctl_regs.sv
`timescale 1ns/1ps
module ser_ctl_regs
  import ser_shift_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ctl_we_i,
  input  logic [2:0] w_mode_i,
  input  logic     w_en_i,
  input  logic     w_req_i,
  input  logic     w_stop_i,
  input  logic     w_start_i,
  input  logic     mode_q_i,
  input  logic     active_i,
  input  logic     done_i,
  output ck_mode_e mode_o,
  output logic     en_o,
  output logic     req_o,
  output logic     stop_o,
  output logic     start_o
);

  ck_mode_e mode_q;
  logic     en_q, req_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= CK_DIV2;
      en_q   <= 1'b0;
      req_q  <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      if (ctl_we_i) begin
        mode_q <= ck_mode_e'(w_mode_i);
        en_q   <= w_en_i;
        stop_q <= w_stop_i;
        if (!w_req_i) req_q <= 1'b0;
      end
      if (done_i) req_q <= 1'b1;
    end
  end

  assign start_o = ctl_we_i & w_start_i & ~mode_q_i & ~active_i;
  assign mode_o  = mode_q;
  assign en_o    = en_q;
  assign req_o   = req_q;
  assign stop_o  = stop_q;

endmodule

// File: rtl/ser_clk_gen.sv
`timescale 1ns/1ps
module ser_clk_gen
  import ser_shift_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ck_mode_e mode_i,
  input  logic     run_i,
  input  logic     start_i,
  input  logic     done_i,
  input  logic     tick_i,
  input  logic     sclk_i,
  output logic     sclk_o,
  output logic     fall_o,
  output logic     rise_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;
  logic                   ext_lvl;
  logic [CNT_W-1:0]       cnt_q;
  logic                   sclk_q;
  logic                   use_ext;
  logic                   int_evt;

  assign use_ext = (mode_i == CK_EXTERN);
  assign ext_lvl = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= sclk_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_prev_q <= 1'b1;
    else         ext_prev_q <= ext_lvl;
  end

  assign int_evt = run_i & ~use_ext & tick_i & (cnt_q == half_limit(mode_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (start_i || done_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (run_i && !use_ext && tick_i) begin
      if (int_evt) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fall_o = use_ext ? (run_i & ext_prev_q & ~ext_lvl) : (int_evt & sclk_q);
  assign rise_o = use_ext ? (run_i & ~ext_prev_q & ext_lvl) : (int_evt & ~sclk_q);
  assign sclk_o = use_ext ? 1'b1 : sclk_q;

endmodule

// File: rtl/ser_shifter.sv
`timescale 1ns/1ps
module ser_shifter
  import ser_shift_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              sin_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] shreg_o,
  output logic [BIT_W-1:0]  bitpos_o,
  output logic              sout_o
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              active_q;
  logic [DATA_W-1:0] shreg_q;
  logic [BIT_W-1:0]  bitpos_q;
  logic              sout_q;

  assign done_o = active_q & rise_i & (bitpos_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      shreg_q  <= '0;
      bitpos_q <= '0;
      sout_q   <= 1'b1;
    end else if (start_i) begin
      active_q <= 1'b1;
      bitpos_q <= '0;
    end else if (active_q) begin
      if (fall_i) sout_q <= shreg_q[0];
      if (rise_i) begin
        shreg_q  <= {sin_i, shreg_q[DATA_W-1:1]};
        bitpos_q <= bitpos_q + 1'b1;
        if (bitpos_q == LAST_BIT) active_q <= 1'b0;
      end
    end else if (load_i) begin
      shreg_q <= load_data_i;
    end
  end

  assign active_o = active_q;
  assign shreg_o  = shreg_q;
  assign bitpos_o = bitpos_q;
  assign sout_o   = sout_q;

endmodule

// File: rtl/ser_shift_ctl.sv
`timescale 1ns/1ps
module ser_shift_ctl
  import ser_shift_pkg::*;
#(
  parameter int              ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        be_i,
  input  logic              wr_i,
  output logic [15:0]       rdata_o,
  input  logic              tick_i,
  input  logic              mode_q_i,
  input  logic              sclk_i,
  input  logic              sin_i,
  output logic              sclk_o,
  output logic              sout_o,
  output logic              irq_o
);

  logic              hit;
  logic              ctl_we, dat_we;
  ck_mode_e          mode;
  logic              en, req, stop_q, start;
  logic              active, done, run;
  logic              fall_evt, rise_evt;
  logic [DATA_W-1:0] shreg;
  logic [BIT_W-1:0]  bitpos;
  logic [7:0]        ctl_rd;
  logic              unused_busy_wr;

  assign hit            = (addr_i == BASE_ADDR);
  assign ctl_we         = hit & wr_i & be_i[1];
  assign dat_we         = hit & wr_i & be_i[0];
  assign run            = active & ~stop_q;
  assign unused_busy_wr = wdata_i[8 + F_BUSY];

  ser_ctl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_we_i  (ctl_we),
    .w_mode_i  (wdata_i[8+F_MODE +: 3]),
    .w_en_i    (wdata_i[8+F_EN]),
    .w_req_i   (wdata_i[8+F_REQ]),
    .w_stop_i  (wdata_i[8+F_STOP]),
    .w_start_i (wdata_i[8+F_START]),
    .mode_q_i  (mode_q_i),
    .active_i  (active),
    .done_i    (done),
    .mode_o    (mode),
    .en_o      (en),
    .req_o     (req),
    .stop_o    (stop_q),
    .start_o   (start)
  );

  ser_clk_gen #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .run_i   (run),
    .start_i (start),
    .done_i  (done),
    .tick_i  (tick_i),
    .sclk_i  (sclk_i),
    .sclk_o  (sclk_o),
    .fall_o  (fall_evt),
    .rise_o  (rise_evt)
  );

  ser_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .fall_i      (fall_evt),
    .rise_i      (rise_evt),
    .sin_i       (sin_i),
    .load_i      (dat_we),
    .load_data_i (wdata_i[DATA_W-1:0]),
    .active_o    (active),
    .done_o      (done),
    .shreg_o     (shreg),
    .bitpos_o    (bitpos),
    .sout_o      (sout_o)
  );

  always_comb begin
    ctl_rd               = '0;
    ctl_rd[F_MODE +: 3]  = mode;
    ctl_rd[F_EN]         = en;
    ctl_rd[F_REQ]        = req;
    ctl_rd[F_BUSY]       = run;
    ctl_rd[F_STOP]       = stop_q;
    ctl_rd[F_START]      = 1'b0;
  end

  assign rdata_o = hit ? {ctl_rd, shreg} : 16'h0000;
  assign irq_o   = req & en;

endmodule

// File: rtl/ser_shift_chk.sv
`timescale 1ns/1ps
module ser_shift_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_q_i,
  input logic       active,
  input logic       stop_q,
  input logic       en,
  input logic       req,
  input logic       done,
  input logic       irq_o,
  input logic       sclk_o,
  input logic [7:0] shreg,
  input logic [2:0] bitpos
);

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q_i && !active) |=> !active);

  // R6
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stop_q && $past(active && stop_q)) |-> ($stable(shreg) && $stable(bitpos)));

  // R7
  req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req && !active));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq_o);

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sclk_o);

endmodule

bind ser_shift_ctl ser_shift_chk u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .mode_q_i (mode_q_i),
  .active   (active),
  .stop_q   (stop_q),
  .en       (en),
  .req      (req),
  .done     (done),
  .irq_o    (irq_o),
  .sclk_o   (sclk_o),
  .shreg    (shreg),
  .bitpos   (bitpos)
);

// File: tb/ser_shift_ctl_tb_top.sv
`timescale 1ns/1ps
module ser_shift_ctl_tb_top;

  localparam real TCLK = 4.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        wr = 1'b0;
  logic [15:0] rdata;
  logic        tick = 1'b1;
  logic        mode_q = 1'b0;
  logic        sclk_in = 1'b1;
  logic        sin = 1'b0;
  logic        sclk_out, sout, irq;

  int n_chk = 0;
  int n_err = 0;
  int tick_gap = 1;
  int tick_ph = 0;
  logic [7:0] slave_byte = '0;
  logic [7:0] cap = '0;
  int bitidx = 0;

  always #2 clk = ~clk;

  ser_shift_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .wr_i(wr), .rdata_o(rdata), .tick_i(tick), .mode_q_i(mode_q),
    .sclk_i(sclk_in), .sin_i(sin), .sclk_o(sclk_out), .sout_o(sout), .irq_o(irq)
  );

  initial forever begin
    @(negedge clk);
    tick_ph = (tick_ph + 1) % tick_gap;
    tick = (tick_ph == 0);
  end

  // Partner model: drive after the falling shift edge, capture on the rising one
  initial forever begin
    @(negedge sclk_out);
    #1;
    sin = slave_byte[bitidx % 8];
    bitidx = bitidx + 1;
  end
  initial forever begin
    @(posedge sclk_out);
    cap = {sout, cap[7:1]};
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] ctl, input logic [7:0] dat, input logic [1:0] en);
    @(negedge clk);
    wdata = {ctl, dat}; be = en; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = 2'b00;
  endtask

  task automatic rd(output logic [15:0] v);
    #1;
    v = rdata;
  endtask

  function automatic logic [7:0] ctlb(input logic [2:0] m, input logic e, input logic r,
                                      input logic s, input logic st);
    return {m, e, r, 1'b0, s, st};
  endfunction

  task automatic wait_done(input string tag);
    logic [15:0] v;
    bit seen = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      rd(v);
      if (v[11]) begin seen = 1; break; end
    end
    chk({tag, " request set"}, 32'(seen), 32'd1);
  endtask

  task automatic launch(input logic [2:0] m, input logic e, input logic [7:0] tx, input logic [7:0] rx);
    bus_wr(8'h00, tx, 2'b01);
    slave_byte = rx; bitidx = 0; cap = '0;
    bus_wr(ctlb(m, e, 1'b0, 1'b0, 1'b1), 8'h00, 2'b10);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    @(negedge clk);
    rd(v);
    chk("R1 control lane", 32'(v[15:8]), 32'h02);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 sclk_o", 32'(sclk_out), 32'd1);
  endtask

  task automatic t_lanes();
    logic [15:0] v;
    bus_wr(8'h00, 8'h5A, 2'b01);
    rd(v);
    chk("R12 data lane write", 32'(v[7:0]), 32'h5A);
    chk("R12 control untouched", 32'(v[15:8]), 32'h02);
    bus_wr(8'hF6, 8'h11, 2'b00);
    rd(v);
    chk("R12 no enables", 32'(v), 32'h025A);
    addr = 4'd3;
    bus_wr(8'hE0, 8'h22, 2'b11);
    rd(v);
    chk("R12 other address reads 0", 32'(v), 32'h0);
    addr = 4'd0;
    rd(v);
    chk("R12 other address write ignored", 32'(v), 32'h025A);
    bus_wr(8'h06, 8'h00, 2'b10);
    rd(v);
    chk("R11 busy not writable", 32'(v[10]), 32'd0);
  endtask

  task automatic t_start_gate();
    logic [15:0] v;
    mode_q = 1'b1;
    bus_wr(ctlb(3'b000, 1'b0, 1'b0, 1'b0, 1'b1), 8'h00, 2'b10);
    rd(v);
    chk("R2 blocked by qualifier", 32'(v[10]), 32'd0);
    chk("R2 start reads 0", 32'(v[8]), 32'd0);
    repeat (10) @(negedge clk);
    chk("R2 no shift clock", 32'(sclk_out), 32'd1);
    mode_q = 1'b0;
    launch(3'b001, 1'b0, 8'hC3, 8'h3C);
    rd(v);
    chk("R2 busy after start", 32'(v[10]), 32'd1);
    chk("R2 start reads 0 while busy", 32'(v[8]), 32'd0);
    wait_done("R7");
    rd(v);
    chk("R7 busy clear at end", 32'(v[10]), 32'd0);
    chk("R4 sent byte", 32'(cap), 32'hC3);
    chk("R4 received byte", 32'(v[7:0]), 32'h3C);
  endtask

  task automatic t_div(input logic [2:0] m, input int div);
    realtime t0, t1;
    launch(m, 1'b0, 8'hA6, 8'h59);
    @(negedge sclk_out); t0 = $realtime;
    @(negedge sclk_out); t1 = $realtime;
    chk($sformatf("R3 period code %0b gap %0d", m, tick_gap),
        32'($rtoi((t1 - t0) / TCLK)), 32'(div * tick_gap));
    wait_done("R3");
    chk("R4 sent byte", 32'(cap), 32'hA6);
    chk("R4 received byte", 32'(rdata[7:0]), 32'h59);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    rd(v);
    chk("R8 request without enable", 32'({v[11], irq}), 32'b10);
    bus_wr(ctlb(3'b000, 1'b1, 1'b1, 1'b0, 1'b0), 8'h00, 2'b10);
    rd(v);
    chk("R9 writing 1 keeps request", 32'(v[11]), 32'd1);
    chk("R8 irq with enable", 32'(irq), 32'd1);
    bus_wr(ctlb(3'b000, 1'b1, 1'b0, 1'b0, 1'b0), 8'h00, 2'b10);
    rd(v);
    chk("R9 writing 0 clears request", 32'(v[11]), 32'd0);
    chk("R8 irq drops", 32'(irq), 32'd0);
    launch(3'b110, 1'b1, 8'h01, 8'h80);
    wait_done("R8");
    chk("R8 irq after enabled transfer", 32'(irq), 32'd1);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    logic s;
    int b0;
    launch(3'b010, 1'b0, 8'h3C, 8'hA5);
    repeat (40) @(negedge clk);
    bus_wr(ctlb(3'b010, 1'b0, 1'b1, 1'b1, 1'b0), 8'h00, 2'b10);
    rd(v);
    chk("R6 busy reads 0 while stopped", 32'(v[10]), 32'd0);
    s = sclk_out; b0 = bitidx;
    repeat (60) @(negedge clk);
    chk("R6 shift clock frozen", 32'(sclk_out), 32'(s));
    chk("R6 bit position held", 32'(bitidx), 32'(b0));
    bus_wr(ctlb(3'b010, 1'b0, 1'b1, 1'b0, 1'b0), 8'h00, 2'b10);
    wait_done("R6");
    chk("R6 sent byte after resume", 32'(cap), 32'h3C);
    chk("R6 received byte after resume", 32'(rdata[7:0]), 32'hA5);
  endtask

  task automatic t_ignore_data();
    launch(3'b001, 1'b0, 8'h96, 8'h0F);
    repeat (3) @(negedge clk);
    bus_wr(8'h00, 8'hFF, 2'b01);
    wait_done("R10");
    chk("R10 sent byte unchanged", 32'(cap), 32'h96);
    chk("R10 received byte unchanged", 32'(rdata[7:0]), 32'h0F);
  endtask

  task automatic t_ext();
    logic [7:0] tx = 8'h4D, rx = 8'hB2, got = '0;
    bit still_high = 1;
    bus_wr(8'h00, tx, 2'b01);
    bus_wr(ctlb(3'b101, 1'b0, 1'b0, 1'b0, 1'b1), 8'h00, 2'b10);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0;
      repeat (6) @(negedge clk);
      sin = rx[i];
      got = {sout, got[7:1]};
      if (!sclk_out) still_high = 0;
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    wait_done("R5");
    chk("R5 sclk_o held high", 32'(still_high), 32'd1);
    chk("R5 sent byte", 32'(got), 32'(tx));
    chk("R5 received byte", 32'(rdata[7:0]), 32'(rx));
  endtask

  initial begin
    #(TCLK * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lanes();
    t_start_gate();
    t_div(3'b000, 2);
    t_div(3'b001, 4);
    t_div(3'b110, 8);
    t_div(3'b010, 16);
    t_div(3'b011, 32);
    t_div(3'b100, 64);
    t_div(3'b111, 128);
    tick_gap = 3;
    t_div(3'b000, 2);
    tick_gap = 1;
    t_irq();
    t_stop();
    t_ignore_data();
    t_ext();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule